// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes three serial stereo audio data lines that share one bit clock and one frame clock. It turns each channel slot into a parallel signed 24-bit sample for every line and raises a strobe when a left/right pair is complete. The bit clock, frame clock and data lines are asynchronous to the system clock. They pass through two-flop synchronizers, and the synchronized bit clock is edge-detected. On each rising bit-clock edge the frame clock and all data lines are captured. Samples are two's complement and arrive MSB first.

Three framings are supported, selected by `fmt_sel`. The left/right polarity of the frame clock and the position of the sample inside its slot both depend on the framing. Resolution is 24, 20, 18 or 16 bits and is selected by `res_sel`. The block counts the bit clocks between frame-clock transitions to learn whether a slot holds 24 or 32 bits. The length learned from the slot just ended places the data of the slot now arriving. A sample is taken on the last bit of its slot in every framing.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset all sample outputs are zero, `smp_valid` is low and `slot_is_32` is high.
- R2: With `fmt_sel` = 2'b10 (left-justified), a high frame clock marks the left slot and a low one the right slot. The sample MSB is the first bit of the slot.
- R3: With `fmt_sel` = 2'b01 (I2S), a low frame clock marks the left slot and a high one the right slot. The sample MSB is the second bit of the slot, one bit clock after the transition.
- R4: With `fmt_sel` = 2'b00 (right-justified), a high frame clock marks the left slot. The sample LSB is the last bit of the slot, and the slot length is the one measured over the previous slot.
- R5: `res_sel` 2'b00/01/10/11 selects 24/20/18/16 bits. The sample MSB sits at output bit 23 and the unused low bits are zero. Slot bits outside the sample window have no effect on the outputs.
- R6: A slot longer than 24 bit clocks is taken as 32 bits long, otherwise as 24. `slot_is_32` shows the length measured over the most recent complete slot.
- R7: `smp_valid` is a one-cycle pulse. It is raised three system clocks after the rising bit-clock edge that carries the last bit of a right slot, provided a left slot was captured just before it. All three lines' left and right samples are valid in that cycle.
- R8: `fmt_sel` = 2'b11 is invalid. `fmt_err` is then high, no strobe is raised, and the sample outputs keep their values.
- R9: No sample is produced until two frame-clock transitions have been seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_clk | input | 1 | Serial bit clock (asynchronous) |
| frame_clk | input | 1 | Left/right frame clock (asynchronous) |
| sdata | input | LINES | Serial data lines |
| fmt_sel | input | 2 | Framing: 00 right-justified, 01 I2S, 10 left-justified, 11 invalid |
| res_sel | input | 2 | Resolution: 00 24-bit, 01 20-bit, 10 18-bit, 11 16-bit |
| left_smp | output | LINES x 24 | Left samples, left-aligned |
| right_smp | output | LINES x 24 | Right samples, left-aligned |
| smp_valid | output | 1 | Pair-complete strobe |
| slot_is_32 | output | 1 | Last measured slot was 32 bits |
| fmt_err | output | 1 | Invalid framing code selected |

## Verification
A rising bit-clock edge needs two system clocks to cross the synchronizer. The captured sample, the strobe and the slot-length flag are then registered on the third clock. For each frame the bench checks that the strobe is still low two clocks after it drives the last right-slot bit clock high. On the third clock after that edge it compares the strobe, all six samples and the slot-length flag. After every change of framing, resolution or slot length, two frames are sent unchecked, so that the length measurement and the left/right pairing have settled before any comparison.

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int LINES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_clk,
  input  logic                   frame_clk,
  input  logic [LINES-1:0]       sdata,
  input  logic [1:0]             fmt_sel,
  input  logic [1:0]             res_sel,
  output logic [LINES-1:0][23:0] left_smp,
  output logic [LINES-1:0][23:0] right_smp,
  output logic                   smp_valid,
  output logic                   slot_is_32,
  output logic                   fmt_err
);
  logic [2:0]             bclk_q;
  logic [1:0]             lr_q;
  logic [LINES-1:0]       sd_q1, sd_q2;
  logic                   lr_prev, got_left;
  logic [5:0]             cnt;
  logic [1:0]             lock;
  logic [LINES-1:0][30:0] sh;
  logic [LINES-1:0][23:0] word;
  logic [4:0]             rbits, top;
  logic [23:0]            mask;

  wire bedge     = bclk_q[1] & ~bclk_q[2];
  wire lr        = lr_q[1];
  wire changed   = lr ^ lr_prev;
  wire [5:0] idx = changed ? 6'd0 : cnt;
  wire slot_left = (fmt_sel == 2'b01) ? ~lr : lr;
  wire last_bit  = idx == (slot_is_32 ? 6'd31 : 6'd23);
  wire emit      = bedge && last_bit && lock == 2'd2 && !fmt_err;

  assign fmt_err = fmt_sel == 2'b11;

  always_comb begin
    case (res_sel)
      2'b00:   rbits = 5'd24;
      2'b01:   rbits = 5'd20;
      2'b10:   rbits = 5'd18;
      default: rbits = 5'd16;
    endcase
    case (fmt_sel)
      2'b00:   top = rbits - 5'd1;
      2'b01:   top = slot_is_32 ? 5'd30 : 5'd22;
      default: top = slot_is_32 ? 5'd31 : 5'd23;
    endcase
    mask = 24'hFFFFFF << (5'd24 - rbits);
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    wire [31:0] sh_n = {sh[g], sd_q2[g]};
    assign word[g] = 24'((sh_n << (5'd31 - top)) >> 8) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q     <= '0;
      lr_q       <= '0;
      sd_q1      <= '0;
      sd_q2      <= '0;
      lr_prev    <= 1'b0;
      cnt        <= '0;
      lock       <= '0;
      slot_is_32 <= 1'b1;
      got_left   <= 1'b0;
      sh         <= '0;
      left_smp   <= '0;
      right_smp  <= '0;
      smp_valid  <= 1'b0;
    end else begin
      bclk_q    <= {bclk_q[1:0], bit_clk};
      lr_q      <= {lr_q[0], frame_clk};
      sd_q1     <= sdata;
      sd_q2     <= sd_q1;
      smp_valid <= 1'b0;
      if (bedge) begin
        lr_prev <= lr;
        for (int k = 0; k < LINES; k++) sh[k] <= {sh[k][29:0], sd_q2[k]};
        if (changed) begin
          cnt        <= 6'd1;
          slot_is_32 <= cnt > 6'd24;
          if (lock != 2'd2) lock <= lock + 2'd1;
        end else if (cnt != 6'd63) begin
          cnt <= cnt + 6'd1;
        end
        if (emit) begin
          got_left <= slot_left;
          if (slot_left) left_smp <= word;
          else begin
            right_smp <= word;
            smp_valid <= got_left;
          end
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid); // R7
  AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_err && $past(fmt_err)) |-> !smp_valid); // R8
  AST_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fmt_err) |-> ($stable(left_smp) && $stable(right_smp))); // R8
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(res_sel) == 2'b11) |-> right_smp[0][7:0] == 8'h00); // R5
  AST_NO_EARLY_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock != 2'd2) |-> !smp_valid); // R9
endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
  logic clk = 0, rst_n = 0, bit_clk = 0, frame_clk = 0;
  logic [2:0] sdata = '0;
  logic [1:0] fmt_sel = 2'b10, res_sel = 2'b00;
  logic [2:0][23:0] left_smp, right_smp;
  logic smp_valid, slot_is_32, fmt_err;
  int checks = 0, fails = 0;
  logic [2:0][23:0] hold_l, hold_r;

  always #5 clk = ~clk;

  audio_serial_rx #(.LINES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_clk(frame_clk),
    .sdata(sdata), .fmt_sel(fmt_sel), .res_sel(res_sel),
    .left_smp(left_smp), .right_smp(right_smp), .smp_valid(smp_valid),
    .slot_is_32(slot_is_32), .fmt_err(fmt_err));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int res_bits(input int r);
    return (r == 0) ? 24 : (r == 1) ? 20 : (r == 2) ? 18 : 16;
  endfunction

  function automatic logic bitval(input int f, input int L, input int rb,
                                  input logic [23:0] v, input int idx, input logic junk);
    int p;
    if (f == 0) begin
      p = idx - (L - rb);
      if (p >= 0) return v[rb-1-p];
    end else begin
      p = (f == 1) ? idx - 1 : idx;
      if (p >= 0 && p < rb) return v[rb-1-p];
    end
    return junk;
  endfunction

  function automatic logic [23:0] expect_word(input logic [23:0] v, input int rb);
    return 24'(v << (24 - rb));
  endfunction

  task automatic send_frame(input int f, input int L, input int r,
                            input logic [2:0][23:0] lv, input logic [2:0][23:0] rv,
                            input bit chk);
    int rb;
    logic lvl;
    string tag;
    rb  = res_bits(r);
    tag = (f == 0) ? "R4" : (f == 1) ? "R3" : "R2";
    for (int s = 0; s < 2; s++) begin
      lvl = (f == 1) ? (s == 1) : (s == 0);
      for (int i = 0; i < L; i++) begin
        bit_clk   = 0;
        frame_clk = lvl;
        for (int k = 0; k < 3; k++)
          sdata[k] = bitval(f, L, rb, (s == 0) ? lv[k] : rv[k], i, 1'($urandom));
        repeat (4) @(negedge clk);
        bit_clk = 1;
        if (chk && s == 1 && i == L - 1) begin
          @(negedge clk);
          @(negedge clk);
          check(smp_valid == 0, "R7", "strobe before third clock", 32'(smp_valid), 0);
          @(negedge clk);
          if (f == 3) begin
            check(smp_valid == 0, "R8", "strobe in invalid mode", 32'(smp_valid), 0);
            check(fmt_err == 1, "R8", "error flag", 32'(fmt_err), 1);
            for (int k = 0; k < 3; k++) begin
              check(left_smp[k] == hold_l[k], "R8", "left held", left_smp[k], hold_l[k]);
              check(right_smp[k] == hold_r[k], "R8", "right held", right_smp[k], hold_r[k]);
            end
          end else begin
            check(smp_valid == 1, "R7", "strobe on third clock", 32'(smp_valid), 1);
            check(slot_is_32 == (L == 32), "R6", "slot length", 32'(slot_is_32), 32'(L == 32));
            for (int k = 0; k < 3; k++) begin
              check(left_smp[k] == expect_word(lv[k], rb), {tag, "/R5"}, "left sample",
                    left_smp[k], expect_word(lv[k], rb));
              check(right_smp[k] == expect_word(rv[k], rb), {tag, "/R5"}, "right sample",
                    right_smp[k], expect_word(rv[k], rb));
            end
          end
          @(negedge clk);
        end else begin
          repeat (4) @(negedge clk);
        end
      end
    end
  endtask

  task automatic rand_vals(input int rb, output logic [2:0][23:0] v);
    for (int k = 0; k < 3; k++) v[k] = 24'($urandom) & 24'((1 << rb) - 1);
  endtask

  task automatic run_config(input int f, input int L, input int r);
    logic [2:0][23:0] a, b;
    int rb;
    rb = res_bits(r);
    fmt_sel = 2'(f);
    res_sel = 2'(r);
    rand_vals(rb, a); rand_vals(rb, b);
    send_frame(f, L, r, a, b, 0);
    send_frame(f, L, r, b, a, 0);
    rand_vals(rb, a); rand_vals(rb, b);
    send_frame(f, L, r, a, b, 1);
    a[0] = 24'(1 << (rb - 1));
    a[1] = 24'((1 << (rb - 1)) - 1);
    a[2] = 24'((1 << rb) - 1);
    b[0] = '0;
    b[1] = 24'(1 << (rb - 1));
    b[2] = 24'((1 << (rb - 1)) - 1);
    send_frame(f, L, r, a, b, 1);
    rand_vals(rb, a); rand_vals(rb, b);
    send_frame(f, L, r, a, b, 1);
  endtask

  initial begin
    logic [2:0][23:0] a, b;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(smp_valid == 0, "R1", "reset strobe", 32'(smp_valid), 0);
    check(slot_is_32 == 1, "R1", "reset slot flag", 32'(slot_is_32), 1);
    check(left_smp == '0, "R1", "reset left", 32'(left_smp[0]), 0);
    check(right_smp == '0, "R1", "reset right", 32'(right_smp[0]), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    rand_vals(24, a); rand_vals(24, b);
    send_frame(2, 32, 0, a, b, 0);
    check(smp_valid == 0 && left_smp == '0, "R9", "no sample before lock",
          32'(left_smp[0]), 0);
    for (int f = 0; f < 3; f++)
      for (int L = 24; L <= 32; L += 8)
        for (int r = 0; r < 4; r++)
          if (!(f == 1 && L == 24 && r == 0)) run_config(f, L, r);
    hold_l = left_smp;
    hold_r = right_smp;
    fmt_sel = 2'b11;
    for (int n = 0; n < 3; n++) begin
      rand_vals(24, a); rand_vals(24, b);
      send_frame(3, 32, 0, a, b, 1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule